// File: doc/BRIEF.md
# Candidate Macroblock Fetch and Align

This block builds one candidate macroblock for a motion-estimation engine out of a reference frame held in two memory banks. The requester gives a start pulse, the position of the current macroblock (in macroblock units) and a signed motion vector. Nothing else is supplied. The block works out everything it needs from those inputs: the sub-macroblock pixel offsets, the base reference macroblock, the bank addresses of the four stored macroblocks that the candidate overlaps, and the amounts for two barrel shifters.

Macroblock columns alternate between the banks. The left and right reference macroblocks of a candidate therefore always lie in different banks, and each step reads one row from both banks at once. The left row is shifted towards lane 0 by the horizontal offset. The right row is shifted towards the high lanes by the macroblock width minus that offset. The two shifted rows are then ORed together, and the candidate is emitted one 16-pixel row per cycle, followed by a completion pulse.

Top module: `cand_mb_fetch`

## Requirements
- R1: While reset is held, and after it is released until a request arrives, row_valid, done, bank0_rd and bank1_rd are all low.
- R2: Pixel lane i of output row r, held in bits [8i+7:8i], equals the reference pixel at frame column 16*mb_x + mv_x + i and frame row 16*mb_y + mv_y + r. The horizontal offset is the low four bits of mv_x. Lanes 0 to 15-offset come from the left macroblock shifted towards lane 0, and the upper offset lanes come from the right macroblock.
- R3: With vertical offset v (the low four bits of mv_y), the output rows are rows v..15 of the upper macroblock pair followed by rows 0..v-1 of the lower pair.
- R4: A negative component rounds the base macroblock towards minus infinity, so its offset is 16 minus (|mv| mod 16). A component that is a negative multiple of 16 gives offset 0, which is a pure macroblock move.
- R5: When the horizontal offset is 0, each output row is exactly the left macroblock row, and the right bank contributes nothing.
- R6: A macroblock in an even column sits in bank 0 and one in an odd column sits in bank 1. A bank address is {macroblock row (3 bits), macroblock column / 2 (3 bits), pixel row (4 bits)}, MSB first. Both banks are read in the same cycle for every output row.
- R7: When the vertical offset is 0, every read addresses the base macroblock row only.
- R8: row_valid first rises two clock edges after the edge that samples start. It then stays high for 16 consecutive cycles, with row_idx counting 0 to 15.
- R9: done is a one-cycle pulse on the cycle after row 15 is presented.
- R10: A start that arrives while a candidate is in progress is ignored: the rows keep their original contents and no extra rows follow.
- R11: Macroblock coordinates wrap modulo the frame size in macroblocks (16 columns, 8 rows), both for the base and for the right or lower neighbour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, sampled when idle |
| mv_x | input | 6 | Signed horizontal motion vector |
| mv_y | input | 6 | Signed vertical motion vector |
| mb_x | input | 4 | Current macroblock column |
| mb_y | input | 3 | Current macroblock row |
| bank0_rd | output | 1 | Bank 0 read strobe |
| bank0_addr | output | 10 | Bank 0 row address |
| bank0_data | input | 128 | Bank 0 read data, one cycle after the strobe |
| bank1_rd | output | 1 | Bank 1 read strobe |
| bank1_addr | output | 10 | Bank 1 row address |
| bank1_data | input | 128 | Bank 1 read data, one cycle after the strobe |
| row_valid | output | 1 | Candidate row valid |
| row_idx | output | 4 | Candidate row number |
| row_data | output | 128 | Candidate row, lane i in bits [8i+7:8i] |
| done | output | 1 | Candidate complete pulse |

## Verification
Counting from the edge that samples start as edge 0, the bank strobes and addresses for row r are present between edges r and r+1. Row r appears after edge r+2, and done appears after edge 18. The bench drives stimulus on a falling edge and counts falling edges from that point. It checks strobes and address fields at counts 1 to 16, rows at counts 3 to 18, done at count 19 and its clearing at count 20, so each sample lands half a cycle after the edge that makes the value. The sweep covers every pair of 6-bit vector components at shifting macroblock positions, which exercises every offset and every case of rounding and wrapping.

// File: rtl/cmb_pkg.sv
package cmb_pkg;
   typedef enum logic {
      LEFT_IN_EVEN = 1'b0,
      LEFT_IN_ODD  = 1'b1
   } lane_swap_e;

   typedef enum logic {
      HALF_UPPER = 1'b0,
      HALF_LOWER = 1'b1
   } mb_half_e;
endpackage

// File: rtl/cmb_offset_calc.sv
module cmb_offset_calc #(
   parameter int MV_W  = 6,
   parameter int MBX_W = 4,
   parameter int MBY_W = 3,
   parameter int LG    = 4
) (
   input  logic signed [MV_W-1:0]  mv_x,
   input  logic signed [MV_W-1:0]  mv_y,
   input  logic        [MBX_W-1:0] mb_x,
   input  logic        [MBY_W-1:0] mb_y,
   output logic        [LG-1:0]    x_off,
   output logic        [LG-1:0]    y_off,
   output logic        [MBX_W-1:0] base_x,
   output logic        [MBY_W-1:0] base_y
);
   // Floor division by the macroblock size and the matching non-negative remainder
   logic signed [MV_W-1:0] quo_x;
   logic signed [MV_W-1:0] quo_y;

   assign quo_x  = mv_x >>> LG;
   assign quo_y  = mv_y >>> LG;
   assign x_off  = mv_x[LG-1:0];
   assign y_off  = mv_y[LG-1:0];
   assign base_x = mb_x + MBX_W'(quo_x);
   assign base_y = mb_y + MBY_W'(quo_y);
endmodule

// File: rtl/cmb_addr_gen.sv
module cmb_addr_gen
   import cmb_pkg::*;
#(
   parameter int MB_N  = 16,
   parameter int MBX_W = 4,
   parameter int MBY_W = 3,
   parameter int LG    = 4,
   parameter int AW    = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LG-1:0]    x_off_in,
   input  logic [LG-1:0]    y_off_in,
   input  logic [MBX_W-1:0] base_x_in,
   input  logic [MBY_W-1:0] base_y_in,
   output logic             bank0_rd,
   output logic [AW-1:0]    bank0_addr,
   output logic             bank1_rd,
   output logic [AW-1:0]    bank1_addr,
   output logic             issue,
   output lane_swap_e       swap,
   output logic [LG-1:0]    x_off,
   output logic [LG-1:0]    step_idx,
   output logic             step_last
);
   localparam logic [LG-1:0] LAST_STEP = LG'(MB_N - 1);
   localparam int COL_W  = MBX_W - 1;
   localparam int COL_LO = LG;
   localparam int ROW_LO = LG + COL_W;

   logic             busy;
   logic [LG-1:0]    step;
   logic [LG:0]      src;
   logic [MBX_W-1:0] bx;
   logic [MBY_W-1:0] by;
   logic [LG-1:0]    xo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         step <= '0;
         src  <= '0;
         bx   <= '0;
         by   <= '0;
         xo   <= '0;
      end else if (!busy) begin
         if (start) begin
            busy <= 1'b1;
            step <= '0;
            src  <= {1'b0, y_off_in};
            bx   <= base_x_in;
            by   <= base_y_in;
            xo   <= x_off_in;
         end
      end else begin
         step <= step + 1'b1;
         src  <= src + 1'b1;
         if (step == LAST_STEP) busy <= 1'b0;
      end
   end

   mb_half_e         half;
   logic [MBY_W-1:0] mb_row;
   logic [COL_W-1:0] even_col;
   logic [COL_W-1:0] odd_col;

   always_comb begin
      half     = mb_half_e'(src[LG]);
      mb_row   = by + MBY_W'(half);
      odd_col  = bx[MBX_W-1:1];
      even_col = bx[MBX_W-1:1] + COL_W'(bx[0]);
   end

   assign bank0_rd   = busy;
   assign bank1_rd   = busy;
   assign bank0_addr = {mb_row, even_col, src[LG-1:0]};
   assign bank1_addr = {mb_row, odd_col, src[LG-1:0]};
   assign issue      = busy;
   assign swap       = lane_swap_e'(bx[0]);
   assign x_off      = xo;
   assign step_idx   = step;
   assign step_last  = (step == LAST_STEP);

   AST_BANK_PAIR: assert property (@(posedge clk) disable iff (!rst_n) bank0_rd |-> ((bank0_addr[ROW_LO +: MBY_W] == bank1_addr[ROW_LO +: MBY_W]) && (bank0_addr[LG-1:0] == bank1_addr[LG-1:0]) && ((bank0_addr[COL_LO +: COL_W] == bank1_addr[COL_LO +: COL_W]) || (bank0_addr[COL_LO +: COL_W] == bank1_addr[COL_LO +: COL_W] + 1'b1)))) else $error("bank pair mismatch"); // R6
   AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n) (bank0_rd && !step_last) |=> bank0_rd) else $error("read run cut short"); // R8
   AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n) (busy && start) |=> (step == $past(step) + 1'b1)) else $error("start while busy disturbed sequence"); // R10
endmodule

// File: rtl/cmb_barrel.sv
module cmb_barrel #(
   parameter int PIX_W       = 8,
   parameter int LANES       = 16,
   parameter bit TOWARD_HIGH = 1'b0,
   localparam int W          = PIX_W * LANES,
   localparam int SH_W       = $clog2(LANES) + 1
) (
   input  logic [W-1:0]    din,
   input  logic [SH_W-1:0] amt,
   output logic [W-1:0]    dout
);
   logic [SH_W:0][W-1:0] stage;

   assign stage[0] = din;

   for (genvar k = 0; k < SH_W; k++) begin : g_stage
      if (TOWARD_HIGH) begin : g_up
         assign stage[k+1] = amt[k] ? (stage[k] << (PIX_W * (1 << k))) : stage[k];
      end else begin : g_down
         assign stage[k+1] = amt[k] ? (stage[k] >> (PIX_W * (1 << k))) : stage[k];
      end
   end

   assign dout = stage[SH_W];
endmodule

// File: rtl/cmb_row_merge.sv
module cmb_row_merge
   import cmb_pkg::*;
#(
   parameter int PIX_W = 8,
   parameter int MB_N  = 16,
   parameter int LG    = 4,
   localparam int ROW_W = PIX_W * MB_N
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  lane_swap_e       in_swap,
   input  logic [LG-1:0]    in_xoff,
   input  logic [LG-1:0]    in_idx,
   input  logic             in_last,
   input  logic [ROW_W-1:0] bank0_data,
   input  logic [ROW_W-1:0] bank1_data,
   output logic             row_valid,
   output logic [LG-1:0]    row_idx,
   output logic [ROW_W-1:0] row_data,
   output logic             row_last
);
   // Stage 1 keeps the row tags in step with the one-cycle bank read
   logic          v1;
   lane_swap_e    sw1;
   logic [LG-1:0] xo1;
   logic [LG-1:0] id1;
   logic          ls1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1  <= 1'b0;
         sw1 <= LEFT_IN_EVEN;
         xo1 <= '0;
         id1 <= '0;
         ls1 <= 1'b0;
      end else begin
         v1  <= in_valid;
         sw1 <= in_swap;
         xo1 <= in_xoff;
         id1 <= in_idx;
         ls1 <= in_last;
      end
   end

   logic [ROW_W-1:0] left_row;
   logic [ROW_W-1:0] right_row;
   logic [ROW_W-1:0] left_sh;
   logic [ROW_W-1:0] right_sh;
   logic [LG:0]      left_amt;
   logic [LG:0]      right_amt;

   always_comb begin
      left_row  = (sw1 == LEFT_IN_ODD) ? bank1_data : bank0_data;
      right_row = (sw1 == LEFT_IN_ODD) ? bank0_data : bank1_data;
      left_amt  = {1'b0, xo1};
      right_amt = (LG + 1)'(MB_N) - {1'b0, xo1};
   end

   cmb_barrel #(.PIX_W(PIX_W), .LANES(MB_N), .TOWARD_HIGH(1'b0)) u_left_shift (
      .din  (left_row),
      .amt  (left_amt),
      .dout (left_sh)
   );

   cmb_barrel #(.PIX_W(PIX_W), .LANES(MB_N), .TOWARD_HIGH(1'b1)) u_right_shift (
      .din  (right_row),
      .amt  (right_amt),
      .dout (right_sh)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_valid <= 1'b0;
         row_idx   <= '0;
         row_data  <= '0;
         row_last  <= 1'b0;
      end else begin
         row_valid <= v1;
         row_idx   <= id1;
         row_data  <= left_sh | right_sh;
         row_last  <= v1 & ls1;
      end
   end
endmodule

// File: rtl/cand_mb_fetch.sv
module cand_mb_fetch
   import cmb_pkg::*;
#(
   parameter int PIX_W = 8,
   parameter int MB_N  = 16,
   parameter int MV_W  = 6,
   parameter int MBX_W = 4,
   parameter int MBY_W = 3,
   localparam int LG    = $clog2(MB_N),
   localparam int AW    = MBY_W + MBX_W - 1 + LG,
   localparam int ROW_W = PIX_W * MB_N
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic signed [MV_W-1:0] mv_x,
   input  logic signed [MV_W-1:0] mv_y,
   input  logic [MBX_W-1:0]       mb_x,
   input  logic [MBY_W-1:0]       mb_y,
   output logic                   bank0_rd,
   output logic [AW-1:0]          bank0_addr,
   input  logic [ROW_W-1:0]       bank0_data,
   output logic                   bank1_rd,
   output logic [AW-1:0]          bank1_addr,
   input  logic [ROW_W-1:0]       bank1_data,
   output logic                   row_valid,
   output logic [LG-1:0]          row_idx,
   output logic [ROW_W-1:0]       row_data,
   output logic                   done
);
   if ((1 << LG) != MB_N || MB_N < 2) begin : g_bad_size
      $error("MB_N must be a power of two of at least 2");
   end
   if (MBX_W < 2) begin : g_bad_cols
      $error("MBX_W must leave one bit for bank selection and one for the column");
   end
   if (MBY_W < 1 || PIX_W < 1) begin : g_bad_width
      $error("MBY_W and PIX_W must be positive");
   end
   if (MV_W <= LG) begin : g_bad_mv
      $error("MV_W must exceed log2 of MB_N");
   end

   logic [LG-1:0]    x_off_c;
   logic [LG-1:0]    y_off_c;
   logic [MBX_W-1:0] base_x_c;
   logic [MBY_W-1:0] base_y_c;

   cmb_offset_calc #(.MV_W(MV_W), .MBX_W(MBX_W), .MBY_W(MBY_W), .LG(LG)) u_offset (
      .mv_x   (mv_x),
      .mv_y   (mv_y),
      .mb_x   (mb_x),
      .mb_y   (mb_y),
      .x_off  (x_off_c),
      .y_off  (y_off_c),
      .base_x (base_x_c),
      .base_y (base_y_c)
   );

   logic          issue;
   lane_swap_e    swap;
   logic [LG-1:0] x_off_r;
   logic [LG-1:0] step_idx;
   logic          step_last;

   cmb_addr_gen #(.MB_N(MB_N), .MBX_W(MBX_W), .MBY_W(MBY_W), .LG(LG), .AW(AW)) u_addr (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .x_off_in   (x_off_c),
      .y_off_in   (y_off_c),
      .base_x_in  (base_x_c),
      .base_y_in  (base_y_c),
      .bank0_rd   (bank0_rd),
      .bank0_addr (bank0_addr),
      .bank1_rd   (bank1_rd),
      .bank1_addr (bank1_addr),
      .issue      (issue),
      .swap       (swap),
      .x_off      (x_off_r),
      .step_idx   (step_idx),
      .step_last  (step_last)
   );

   logic row_last;

   cmb_row_merge #(.PIX_W(PIX_W), .MB_N(MB_N), .LG(LG)) u_merge (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (issue),
      .in_swap    (swap),
      .in_xoff    (x_off_r),
      .in_idx     (step_idx),
      .in_last    (step_last),
      .bank0_data (bank0_data),
      .bank1_data (bank1_data),
      .row_valid  (row_valid),
      .row_idx    (row_idx),
      .row_data   (row_data),
      .row_last   (row_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done <= 1'b0;
      else        done <= row_last;
   end

   AST_FIRST_ROW: assert property (@(posedge clk) disable iff (!rst_n) $rose(row_valid) |-> (row_idx == '0)) else $error("first row index not zero"); // R8
   AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n) (row_valid && row_idx != LG'(MB_N - 1)) |=> (row_valid && row_idx == $past(row_idx) + 1'b1)) else $error("row sequence broken"); // R8
   AST_DONE_LAST: assert property (@(posedge clk) disable iff (!rst_n) done |-> ($past(row_valid) && $past(row_idx) == LG'(MB_N - 1))) else $error("done not after last row"); // R9
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done) else $error("done longer than one cycle"); // R9
endmodule

// File: tb/cand_mb_fetch_test.sv
`timescale 1ns/1ps
module cand_mb_fetch_test;
   logic              clk = 1'b0;
   logic              rst_n;
   logic              start;
   logic signed [5:0] mv_x;
   logic signed [5:0] mv_y;
   logic [3:0]        mb_x;
   logic [2:0]        mb_y;
   logic              bank0_rd;
   logic [9:0]        bank0_addr;
   logic [127:0]      bank0_data;
   logic              bank1_rd;
   logic [9:0]        bank1_addr;
   logic [127:0]      bank1_data;
   logic              row_valid;
   logic [3:0]        row_idx;
   logic [127:0]      row_data;
   logic              done;

   int  checks   = 0;
   int  failures = 0;
   bit  finished = 1'b0;

   logic [127:0] mem0 [1024];
   logic [127:0] mem1 [1024];

   always #2 clk = ~clk;

   cand_mb_fetch uut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .mv_x(mv_x), .mv_y(mv_y), .mb_x(mb_x), .mb_y(mb_y),
      .bank0_rd(bank0_rd), .bank0_addr(bank0_addr), .bank0_data(bank0_data),
      .bank1_rd(bank1_rd), .bank1_addr(bank1_addr), .bank1_data(bank1_data),
      .row_valid(row_valid), .row_idx(row_idx), .row_data(row_data), .done(done)
   );

   always @(posedge clk) begin
      if (bank0_rd) bank0_data <= mem0[bank0_addr];
      if (bank1_rd) bank1_data <= mem1[bank1_addr];
   end

   function automatic logic [7:0] pix(int gx, int gy);
      int wx = ((gx % 256) + 256) % 256;
      int wy = ((gy % 128) + 128) % 128;
      return 8'((wx * 7 + wy * 13 + 5) & 255);
   endfunction

   function automatic logic [127:0] exp_row(int mvx, int mvy, int mbx, int mby, int r);
      logic [127:0] v = '0;
      for (int i = 0; i < 16; i++)
         v[8*i +: 8] = pix(mbx * 16 + mvx + i, mby * 16 + mvy + r);
      return v;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run(input int mvx, input int mvy, input int mbx, input int mby, input bit bump);
      int    yoff  = mvy & 15;
      int    xoff  = mvx & 15;
      int    by_e  = (((mby + (mvy - yoff) / 16) % 8) + 8) % 8;
      int    gx0   = mbx * 16 + mvx;
      int    gy0   = mby * 16 + mvy;
      string tag;
      if (gx0 < 0 || gx0 + 15 > 255 || gy0 < 0 || gy0 + 15 > 127) tag = "R11";
      else if (mvx < 0 || mvy < 0) tag = "R4";
      else if (xoff == 0)          tag = "R5";
      else if (yoff != 0)          tag = "R3";
      else                         tag = "R2";
      start = 1'b1;
      mv_x  = 6'(mvx);
      mv_y  = 6'(mvy);
      mb_x  = 4'(mbx);
      mb_y  = 3'(mby);
      for (int c = 1; c <= 20; c++) begin
         @(negedge clk);
         if (c == 1) start = 1'b0;
         if (bump && c == 5) begin
            start = 1'b1;
            mv_x  = 6'(mvx + 3);
            mv_y  = 6'(mvy + 5);
         end
         if (bump && c == 6) start = 1'b0;
         if (c == 2) chk(!row_valid, "R8 early row", 128'(row_valid), 128'(0));
         if (c >= 1 && c <= 16) begin
            chk(bank0_rd && bank1_rd, "R6 paired read", 128'({bank0_rd, bank1_rd}), 128'(3));
            if (yoff == 0)
               chk(bank0_addr[9:7] == 3'(by_e) && bank1_addr[9:7] == 3'(by_e), "R7 upper row only",
                   128'({bank0_addr[9:7], bank1_addr[9:7]}), 128'({3'(by_e), 3'(by_e)}));
         end
         if (c >= 3 && c <= 18) begin
            chk(row_valid && row_idx == 4'(c - 3), "R8 row timing",
                128'({row_valid, row_idx}), 128'({1'b1, 4'(c - 3)}));
            chk(row_data == exp_row(mvx, mvy, mbx, mby, c - 3), bump ? "R10 data kept" : tag,
                row_data, exp_row(mvx, mvy, mbx, mby, c - 3));
         end
         if (c == 19) chk(done && !row_valid, "R9 done after last row", 128'({done, row_valid}), 128'(2));
         if (c == 20) chk(!done, "R9 done single cycle", 128'(done), 128'(0));
      end
   endtask

   initial begin
      for (int a = 0; a < 1024; a++) begin
         for (int i = 0; i < 16; i++) begin
            mem0[a][8*i +: 8] = pix((2 * ((a >> 4) & 7)) * 16 + i, (a >> 7) * 16 + (a & 15));
            mem1[a][8*i +: 8] = pix((2 * ((a >> 4) & 7) + 1) * 16 + i, (a >> 7) * 16 + (a & 15));
         end
      end
      rst_n = 1'b0;
      start = 1'b0;
      mv_x  = '0;
      mv_y  = '0;
      mb_x  = '0;
      mb_y  = '0;
      repeat (3) @(negedge clk);
      chk(!row_valid && !done && !bank0_rd && !bank1_rd, "R1 in reset",
          128'({row_valid, done, bank0_rd, bank1_rd}), 128'(0));
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!row_valid && !done && !bank0_rd && !bank1_rd, "R1 after reset",
          128'({row_valid, done, bank0_rd, bank1_rd}), 128'(0));
      run(7, 9, 3, 2, 1'b1);
      repeat (3) begin
         @(negedge clk);
         chk(!row_valid && !bank0_rd, "R10 no extra rows", 128'({row_valid, bank0_rd}), 128'(0));
      end
      begin
         int n = 0;
         for (int vx = -32; vx < 32; vx++) begin
            for (int vy = -32; vy < 32; vy++) begin
               run(vx, vy, (n * 5) & 15, (n * 3) & 7, 1'b0);
               n++;
            end
         end
      end
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (195000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule